// File: doc/BRIEF.md
# Reorder Buffer with In-Order Commit

This block holds the in-flight instructions of an out-of-order core in program order and retires them in that order. Each cycle rename may hand over a small group of instructions. Every instruction carries a sequence number, a PC and four flags: squashed, non-speculative, branch and no-op. Each instruction takes the next free slot of a circular buffer. Execute reports finished instructions by slot number. The block then retires ready instructions from the oldest end, up to a fixed number per cycle.

When execute reports a wrong path, it gives the sequence number of the last instruction to keep. The controller then enters a squash walk. Over several cycles it steps backwards from the youngest entry and marks every younger instruction as squashed. Marked entries stay in place and later leave the head without being counted as committed. An instruction that must run non-speculatively is not executed when it reaches the head. In that case the block asks execute, once, to run it, and stalls until completion arrives.

Every cycle the block reports back upstream. It gives the free-slot count and the last done sequence number. It also gives pulses for squash and walk-in-progress, the forwarded redirect fields and a non-speculative run request. Running counters record commits, silent retirements, branches, non-NOP commits and mispredicts.

Top module: `rob_commit_ctrl`

## Requirements
- R1: After synchronous reset the controller state is Idle (encoding 0). The free count equals DEPTH, `ins_ready` is 1, and `done_seq` and all counters are 0.
- R2: A group accepted in a cycle places its valid lanes that are not flagged squashed into consecutive slots, lane 0 first, starting at the tail. Lanes flagged squashed are dropped. Slot numbers start at 0 after reset and wrap modulo DEPTH. `free_cnt` reflects the insert after the clock edge.
- R3: `ins_ready` is 0 while the state is Squashing (encoding 2), and also while fewer than IN_W slots are free. A group offered while `ins_ready` is 0, or in the same cycle as a squash request, is not inserted.
- R4: A completion for a slot makes that entry ready from the next cycle on. Up to CW entries retire per cycle, oldest first, and retirement stops at the first head entry that is neither ready nor squashed.
- R5: Each cycle `commit_num` gives the number of entries committed, and `done_seq` takes the sequence number of the youngest one. `cnt_committed` counts every commit, `cnt_branch` counts committed branches, and `cnt_nonnop` counts commits not flagged no-op.
- R6: An entry marked squashed retires when it reaches the head, whether or not it completed. It adds to `cnt_sq_retired`, not to `cnt_committed`, and it leaves `done_seq` unchanged.
- R7: An incomplete head entry flagged non-speculative raises `ns_valid` for one cycle with its sequence number on `ns_seq`, once per entry. Nothing at or behind it retires until its completion arrives.
- R8: A squash request outside Squashing moves the state to Squashing. In the next cycle `done_seq` is the request's sequence number, `bk_squash` and `bk_rob_squashing` are 1, and the taken flag, mispredict flag, next PC and mispredicted PC are forwarded. `cnt_mispred` increments only when the mispredict flag is set.
- R9: In each Squashing cycle, up to CW of the youngest unmarked entries whose sequence number is greater than the squash number are marked. `done_seq` then shows the youngest remaining entry's number, or the squash number if none remains, and `bk_rob_squashing` is 1. A cycle that finds nothing to mark returns the state to Running (encoding 1). No insert and no retirement happen in Squashing.
- R10: The state leaves Idle for Running on the first cycle an instruction is inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | IN_W | Lane valid of the rename group |
| ins_squashed | input | IN_W | Lane already squashed, drop it |
| ins_nonspec | input | IN_W | Lane must run non-speculatively |
| ins_branch | input | IN_W | Lane is a branch |
| ins_nop | input | IN_W | Lane is a no-op |
| ins_seq | input | IN_W*SEQ_W | Lane sequence numbers, lane 0 in the low bits |
| ins_pc | input | IN_W*PC_W | Lane PCs |
| ins_ready | output | 1 | Group can be accepted this cycle |
| cmp_valid | input | CMP_W | Completion port valid |
| cmp_slot | input | CMP_W*log2(DEPTH) | Buffer slot completed per port |
| xs_valid | input | 1 | Squash request from execute |
| xs_seq | input | SEQ_W | Youngest sequence number to keep |
| xs_mispred | input | 1 | Request stems from a mispredict |
| xs_taken | input | 1 | Branch outcome taken |
| xs_next_pc | input | PC_W | Redirect target |
| xs_mis_pc | input | PC_W | PC of the mispredicted branch |
| ctl_state | output | 2 | 0 Idle, 1 Running, 2 Squashing |
| free_cnt | output | log2(DEPTH)+1 | Free slots |
| done_seq | output | SEQ_W | Last done sequence number |
| bk_squash | output | 1 | Squash pulse upstream |
| bk_rob_squashing | output | 1 | Walk in progress pulse |
| bk_mispred | output | 1 | Forwarded mispredict flag |
| bk_taken | output | 1 | Forwarded taken flag |
| bk_next_pc | output | PC_W | Forwarded redirect target |
| bk_mis_pc | output | PC_W | Forwarded mispredicted PC |
| ns_valid | output | 1 | Run request for non-speculative head |
| ns_seq | output | SEQ_W | Its sequence number |
| commit_num | output | log2(CW+1) | Entries committed this cycle |
| head_pc | output | PC_W | PC of the head slot |
| cnt_committed | output | CNT_W | Committed instructions |
| cnt_sq_retired | output | CNT_W | Silently retired entries |
| cnt_branch | output | CNT_W | Committed branches |
| cnt_nonnop | output | CNT_W | Committed non-NOP instructions |
| cnt_mispred | output | CNT_W | Mispredict squashes |

## Verification
The bench targets six corner cases.
- A completion that arrives out of order must not let a younger entry retire past an unfinished head; a design that skipped the head would move `done_seq` too early.
- A group offered on a full buffer or alongside a squash must be dropped; a leaky design would lose free slots.
- A walk spans two steps, and its output sequence numbers are checked step by step. An off-by-one pointer would mark the kept entry, or would leave Squashing a cycle late or early.
- The marked entries then reach the head, and they must drain without counting as commits or moving `done_seq`.
- A non-speculative head must request exactly once and block the completed entry behind it.
- A squash without the mispredict flag must leave the mispredict counter alone.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_SQ   = 2'd2
  } rob_state_e;
endpackage

// File: rtl/rob_alloc.sv
module rob_alloc #(
  parameter int IN_W  = 2,
  localparam int OFF_W = $clog2(IN_W + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        grp_take,
  input  logic [IN_W-1:0]             grp_valid,
  input  logic [IN_W-1:0]             grp_sqd,
  output logic [IN_W-1:0]             lane_we,
  output logic [IN_W-1:0][OFF_W-1:0]  lane_off,
  output logic [OFF_W-1:0]            ins_n
);
  always_comb begin
    logic [OFF_W-1:0] acc;
    acc = '0;
    lane_we = '0;
    for (int l = 0; l < IN_W; l++) begin
      lane_off[l] = acc;
      if (grp_take && grp_valid[l] && !grp_sqd[l]) begin
        lane_we[l] = 1'b1;
        acc = acc + OFF_W'(1);
      end
    end
    ins_n = acc;
  end

  // R2: never more lanes written than a group holds
  p_ins_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (32'(ins_n) <= IN_W) && (32'(ins_n) == $countones(lane_we)));
endmodule

// File: rtl/rob_retire.sv
module rob_retire #(
  parameter int DEPTH = 16,
  parameter int CW    = 2,
  parameter int SEQ_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1,
  localparam int RN_W  = $clog2(CW + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  input  logic [IDX_W-1:0]            head_idx,
  input  logic [PTR_W-1:0]            occ,
  input  logic [DEPTH-1:0]            done_v,
  input  logic [DEPTH-1:0]            sqd_v,
  input  logic [DEPTH-1:0]            req_v,
  input  logic [DEPTH-1:0]            ns_v,
  input  logic [DEPTH-1:0]            br_v,
  input  logic [DEPTH-1:0]            nop_v,
  input  logic [DEPTH-1:0][SEQ_W-1:0] seq_a,
  output logic [RN_W-1:0]             ret_n,
  output logic [RN_W-1:0]             com_n,
  output logic [RN_W-1:0]             sqr_n,
  output logic [RN_W-1:0]             br_n,
  output logic [RN_W-1:0]             nn_n,
  output logic                        last_vld,
  output logic [SEQ_W-1:0]            last_seq,
  output logic                        ns_fire,
  output logic [IDX_W-1:0]            ns_idx
);
  always_comb begin
    logic go;
    logic [IDX_W-1:0] idx;
    go = en;
    ret_n = '0; com_n = '0; sqr_n = '0; br_n = '0; nn_n = '0;
    last_vld = 1'b0; last_seq = '0; ns_fire = 1'b0; ns_idx = '0;
    for (int k = 0; k < CW; k++) begin
      idx = head_idx + IDX_W'(k);
      if (go && (PTR_W'(k) < occ)) begin
        if (sqd_v[idx]) begin
          ret_n = ret_n + RN_W'(1);
          sqr_n = sqr_n + RN_W'(1);
        end else if (done_v[idx]) begin
          ret_n = ret_n + RN_W'(1);
          com_n = com_n + RN_W'(1);
          br_n  = br_n + RN_W'(br_v[idx]);
          nn_n  = nn_n + RN_W'(!nop_v[idx]);
          last_vld = 1'b1;
          last_seq = seq_a[idx];
        end else begin
          if (ns_v[idx] && !req_v[idx]) begin
            ns_fire = 1'b1;
            ns_idx  = idx;
          end
          go = 1'b0;
        end
      end else begin
        go = 1'b0;
      end
    end
  end

  // R4: retirement bounded by width and by occupancy
  p_ret_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (32'(ret_n) <= CW) && (PTR_W'(ret_n) <= occ));
  // R6: commits plus silent retirements make up all retirements
  p_ret_split_r6: assert property (@(posedge clk) disable iff (rst)
    (32'(com_n) + 32'(sqr_n)) == 32'(ret_n));
endmodule

// File: rtl/rob_walk.sv
module rob_walk #(
  parameter int DEPTH = 16,
  parameter int CW    = 2,
  parameter int SEQ_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1,
  localparam int RN_W  = $clog2(CW + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  input  logic [PTR_W-1:0]            wptr,
  input  logic [PTR_W-1:0]            head,
  input  logic [DEPTH-1:0][SEQ_W-1:0] seq_a,
  input  logic [SEQ_W-1:0]            cut_seq,
  output logic [RN_W-1:0]             step_n,
  output logic [SEQ_W-1:0]            next_seq
);
  logic [PTR_W-1:0] span;
  logic [PTR_W-1:0] remain;

  assign span = wptr - head;

  always_comb begin
    logic go;
    logic [PTR_W-1:0] p;
    go = en;
    step_n = '0;
    for (int k = 0; k < CW; k++) begin
      p = wptr - PTR_W'(k + 1);
      if (go && (PTR_W'(k) < span) && (seq_a[p[IDX_W-1:0]] > cut_seq)) begin
        step_n = step_n + RN_W'(1);
      end else begin
        go = 1'b0;
      end
    end
  end

  always_comb begin
    logic [PTR_W-1:0] q;
    remain = wptr - PTR_W'(step_n);
    q = remain - PTR_W'(1);
    next_seq = (remain == head) ? cut_seq : seq_a[q[IDX_W-1:0]];
  end

  // R9: the walk never passes the head
  p_walk_span_r9: assert property (@(posedge clk) disable iff (rst)
    en |-> (PTR_W'(step_n) <= span));
endmodule

// File: rtl/rob_commit_ctrl.sv
module rob_commit_ctrl #(
  parameter int DEPTH = 16,
  parameter int IN_W  = 2,
  parameter int CW    = 2,
  parameter int CMP_W = 2,
  parameter int SEQ_W = 8,
  parameter int PC_W  = 16,
  parameter int CNT_W = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [IN_W-1:0]                   ins_valid,
  input  logic [IN_W-1:0]                   ins_squashed,
  input  logic [IN_W-1:0]                   ins_nonspec,
  input  logic [IN_W-1:0]                   ins_branch,
  input  logic [IN_W-1:0]                   ins_nop,
  input  logic [IN_W*SEQ_W-1:0]             ins_seq,
  input  logic [IN_W*PC_W-1:0]              ins_pc,
  output logic                              ins_ready,
  input  logic [CMP_W-1:0]                  cmp_valid,
  input  logic [CMP_W*$clog2(DEPTH)-1:0]    cmp_slot,
  input  logic                              xs_valid,
  input  logic [SEQ_W-1:0]                  xs_seq,
  input  logic                              xs_mispred,
  input  logic                              xs_taken,
  input  logic [PC_W-1:0]                   xs_next_pc,
  input  logic [PC_W-1:0]                   xs_mis_pc,
  output logic [1:0]                        ctl_state,
  output logic [$clog2(DEPTH):0]            free_cnt,
  output logic [SEQ_W-1:0]                  done_seq,
  output logic                              bk_squash,
  output logic                              bk_rob_squashing,
  output logic                              bk_mispred,
  output logic                              bk_taken,
  output logic [PC_W-1:0]                   bk_next_pc,
  output logic [PC_W-1:0]                   bk_mis_pc,
  output logic                              ns_valid,
  output logic [SEQ_W-1:0]                  ns_seq,
  output logic [$clog2(CW+1)-1:0]           commit_num,
  output logic [PC_W-1:0]                   head_pc,
  output logic [CNT_W-1:0]                  cnt_committed,
  output logic [CNT_W-1:0]                  cnt_sq_retired,
  output logic [CNT_W-1:0]                  cnt_branch,
  output logic [CNT_W-1:0]                  cnt_nonnop,
  output logic [CNT_W-1:0]                  cnt_mispred
);
  import rob_pkg::*;

  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = IDX_W + 1;
  localparam int RN_W  = $clog2(CW + 1);
  localparam int OFF_W = $clog2(IN_W + 1);

  rob_state_e state_q;
  logic [PTR_W-1:0] head_q, tail_q, wptr_q, head_nx, tail_nx, occ;
  logic [SEQ_W-1:0] cut_q;

  // payload storage, written only at insert, no reset
  logic [DEPTH-1:0][SEQ_W-1:0] seq_mem;
  logic [PC_W-1:0]             pc_mem [DEPTH];
  logic [DEPTH-1:0]            br_mem, nop_mem, ns_mem;
  // per-slot status
  logic [DEPTH-1:0]            done_q, sqd_q, req_q;

  logic grp_take, ret_en, walk_en;
  logic [IN_W-1:0]            lane_we;
  logic [IN_W-1:0][OFF_W-1:0] lane_off;
  logic [OFF_W-1:0]           ins_n;
  logic [IDX_W-1:0]           wr_idx [IN_W];

  logic [RN_W-1:0]  ret_n, com_n, sqr_n, br_n, nn_n;
  logic             last_vld, ns_fire;
  logic [SEQ_W-1:0] last_seq;
  logic [IDX_W-1:0] ns_idx;

  logic [RN_W-1:0]  step_n;
  logic [SEQ_W-1:0] walk_seq;
  logic [IDX_W-1:0] mark_idx [CW];

  assign occ       = tail_q - head_q;
  assign ins_ready = (state_q != ST_SQ) && ((PTR_W'(DEPTH) - occ) >= PTR_W'(IN_W));
  assign grp_take  = ins_ready && !xs_valid;
  assign ret_en    = (state_q != ST_SQ) && !xs_valid;
  assign walk_en   = (state_q == ST_SQ);
  assign ctl_state = state_q;
  assign head_pc   = pc_mem[head_q[IDX_W-1:0]];

  rob_alloc #(.IN_W(IN_W)) u_alloc (
    .clk(clk), .rst(rst), .grp_take(grp_take), .grp_valid(ins_valid),
    .grp_sqd(ins_squashed), .lane_we(lane_we), .lane_off(lane_off), .ins_n(ins_n)
  );

  rob_retire #(.DEPTH(DEPTH), .CW(CW), .SEQ_W(SEQ_W)) u_retire (
    .clk(clk), .rst(rst), .en(ret_en), .head_idx(head_q[IDX_W-1:0]), .occ(occ),
    .done_v(done_q), .sqd_v(sqd_q), .req_v(req_q), .ns_v(ns_mem), .br_v(br_mem),
    .nop_v(nop_mem), .seq_a(seq_mem), .ret_n(ret_n), .com_n(com_n), .sqr_n(sqr_n),
    .br_n(br_n), .nn_n(nn_n), .last_vld(last_vld), .last_seq(last_seq),
    .ns_fire(ns_fire), .ns_idx(ns_idx)
  );

  rob_walk #(.DEPTH(DEPTH), .CW(CW), .SEQ_W(SEQ_W)) u_walk (
    .clk(clk), .rst(rst), .en(walk_en), .wptr(wptr_q), .head(head_q),
    .seq_a(seq_mem), .cut_seq(cut_q), .step_n(step_n), .next_seq(walk_seq)
  );

  always_comb begin
    head_nx = head_q + PTR_W'(ret_n);
    tail_nx = tail_q + PTR_W'(ins_n);
    for (int l = 0; l < IN_W; l++) begin
      wr_idx[l] = tail_q[IDX_W-1:0] + IDX_W'(lane_off[l]);
    end
    for (int k = 0; k < CW; k++) begin
      mark_idx[k] = wptr_q[IDX_W-1:0] - IDX_W'(k + 1);
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < IN_W; l++) begin
      if (lane_we[l]) begin
        seq_mem[wr_idx[l]] <= ins_seq[l*SEQ_W +: SEQ_W];
        pc_mem[wr_idx[l]]  <= ins_pc[l*PC_W +: PC_W];
        br_mem[wr_idx[l]]  <= ins_branch[l];
        nop_mem[wr_idx[l]] <= ins_nop[l];
        ns_mem[wr_idx[l]]  <= ins_nonspec[l];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= '0;
      sqd_q  <= '0;
      req_q  <= '0;
    end else begin
      for (int c = 0; c < CMP_W; c++) begin
        if (cmp_valid[c]) done_q[cmp_slot[c*IDX_W +: IDX_W]] <= 1'b1;
      end
      if (walk_en) begin
        for (int k = 0; k < CW; k++) begin
          if (RN_W'(k) < step_n) sqd_q[mark_idx[k]] <= 1'b1;
        end
      end
      if (ns_fire) req_q[ns_idx] <= 1'b1;
      for (int l = 0; l < IN_W; l++) begin
        if (lane_we[l]) begin
          done_q[wr_idx[l]] <= 1'b0;
          sqd_q[wr_idx[l]]  <= 1'b0;
          req_q[wr_idx[l]]  <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      head_q <= '0; tail_q <= '0; wptr_q <= '0; cut_q <= '0;
      free_cnt <= ($clog2(DEPTH)+1)'(DEPTH);
      done_seq <= '0;
      bk_squash <= 1'b0; bk_rob_squashing <= 1'b0;
      bk_mispred <= 1'b0; bk_taken <= 1'b0;
      bk_next_pc <= '0; bk_mis_pc <= '0;
      ns_valid <= 1'b0; ns_seq <= '0; commit_num <= '0;
      cnt_committed <= '0; cnt_sq_retired <= '0; cnt_branch <= '0;
      cnt_nonnop <= '0; cnt_mispred <= '0;
    end else begin
      bk_squash <= 1'b0;
      bk_rob_squashing <= 1'b0;
      ns_valid <= 1'b0;
      commit_num <= com_n;
      head_q <= head_nx;
      tail_q <= tail_nx;
      free_cnt <= PTR_W'(DEPTH) - (tail_nx - head_nx);
      cnt_committed  <= cnt_committed + CNT_W'(com_n);
      cnt_sq_retired <= cnt_sq_retired + CNT_W'(sqr_n);
      cnt_branch     <= cnt_branch + CNT_W'(br_n);
      cnt_nonnop     <= cnt_nonnop + CNT_W'(nn_n);
      if (state_q == ST_SQ) begin
        if (step_n == '0) begin
          state_q <= ST_RUN;
        end else begin
          wptr_q <= wptr_q - PTR_W'(step_n);
          done_seq <= walk_seq;
          bk_rob_squashing <= 1'b1;
        end
      end else if (xs_valid) begin
        state_q <= ST_SQ;
        cut_q <= xs_seq;
        wptr_q <= tail_q;
        done_seq <= xs_seq;
        bk_squash <= 1'b1;
        bk_rob_squashing <= 1'b1;
        bk_mispred <= xs_mispred;
        bk_taken <= xs_taken;
        bk_next_pc <= xs_next_pc;
        bk_mis_pc <= xs_mis_pc;
        if (xs_mispred) cnt_mispred <= cnt_mispred + CNT_W'(1);
      end else begin
        if (last_vld) done_seq <= last_seq;
        if (ns_fire) begin
          ns_valid <= 1'b1;
          ns_seq <= seq_mem[ns_idx];
        end
        if (state_q == ST_IDLE && ins_n != '0) state_q <= ST_RUN;
      end
    end
  end

  // R2: occupancy never exceeds the buffer
  p_occ_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (tail_q - head_q) <= PTR_W'(DEPTH));
  // R9: pointers frozen while walking
  p_sq_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SQ) |=> (tail_q == $past(tail_q)) && (head_q == $past(head_q)));
  // R8: squash request enters the walk and echoes its number
  p_sq_entry_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_SQ && xs_valid) |=>
      (state_q == ST_SQ) && bk_squash && bk_rob_squashing && (done_seq == $past(xs_seq)));
  // R10: first insert leaves Idle
  p_idle_exit_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !xs_valid && ins_n != '0) |=> (state_q == ST_RUN));
  // R7: a run request stops commit short of full width
  p_ns_stall_r7: assert property (@(posedge clk) disable iff (rst)
    ns_valid |-> (32'(commit_num) < CW));
endmodule

// File: tb/rob_commit_ctrl_tb.sv
`timescale 1ns/1ps
module rob_commit_ctrl_tb;
  localparam int DEPTH = 8, IN_W = 2, CW = 2, CMP_W = 2, SEQ_W = 8, PC_W = 16, CNT_W = 16;
  localparam int IDX_W = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic [IN_W-1:0] ins_valid, ins_squashed, ins_nonspec, ins_branch, ins_nop;
  logic [IN_W*SEQ_W-1:0] ins_seq;
  logic [IN_W*PC_W-1:0] ins_pc;
  logic ins_ready;
  logic [CMP_W-1:0] cmp_valid;
  logic [CMP_W*IDX_W-1:0] cmp_slot;
  logic xs_valid, xs_mispred, xs_taken;
  logic [SEQ_W-1:0] xs_seq;
  logic [PC_W-1:0] xs_next_pc, xs_mis_pc;
  logic [1:0] ctl_state;
  logic [IDX_W:0] free_cnt;
  logic [SEQ_W-1:0] done_seq, ns_seq;
  logic bk_squash, bk_rob_squashing, bk_mispred, bk_taken, ns_valid;
  logic [PC_W-1:0] bk_next_pc, bk_mis_pc, head_pc;
  logic [1:0] commit_num;
  logic [CNT_W-1:0] cnt_committed, cnt_sq_retired, cnt_branch, cnt_nonnop, cnt_mispred;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rob_commit_ctrl #(.DEPTH(DEPTH), .IN_W(IN_W), .CW(CW), .CMP_W(CMP_W), .SEQ_W(SEQ_W),
                    .PC_W(PC_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_squashed(ins_squashed),
    .ins_nonspec(ins_nonspec), .ins_branch(ins_branch), .ins_nop(ins_nop),
    .ins_seq(ins_seq), .ins_pc(ins_pc), .ins_ready(ins_ready),
    .cmp_valid(cmp_valid), .cmp_slot(cmp_slot), .xs_valid(xs_valid), .xs_seq(xs_seq),
    .xs_mispred(xs_mispred), .xs_taken(xs_taken), .xs_next_pc(xs_next_pc),
    .xs_mis_pc(xs_mis_pc), .ctl_state(ctl_state), .free_cnt(free_cnt),
    .done_seq(done_seq), .bk_squash(bk_squash), .bk_rob_squashing(bk_rob_squashing),
    .bk_mispred(bk_mispred), .bk_taken(bk_taken), .bk_next_pc(bk_next_pc),
    .bk_mis_pc(bk_mis_pc), .ns_valid(ns_valid), .ns_seq(ns_seq),
    .commit_num(commit_num), .head_pc(head_pc), .cnt_committed(cnt_committed),
    .cnt_sq_retired(cnt_sq_retired), .cnt_branch(cnt_branch), .cnt_nonnop(cnt_nonnop),
    .cnt_mispred(cnt_mispred)
  );

  typedef struct packed {
    logic [1:0] v;
    logic [7:0] s0;
    logic [7:0] s1;
    logic [1:0] sq;
    logic [1:0] cv;
    logic [2:0] c0;
    logic [2:0] c1;
    logic [3:0] free;
    logic [1:0] cn;
    logic [7:0] ds;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{2'b11, 8'd10, 8'd11, 2'b00, 2'b00, 3'd0, 3'd0, 4'd6, 2'd0, 8'd0},
    '{2'b11, 8'd12, 8'd13, 2'b00, 2'b01, 3'd1, 3'd0, 4'd4, 2'd0, 8'd0},
    '{2'b00, 8'd0,  8'd0,  2'b00, 2'b01, 3'd0, 3'd0, 4'd4, 2'd0, 8'd0},
    '{2'b00, 8'd0,  8'd0,  2'b00, 2'b00, 3'd0, 3'd0, 4'd6, 2'd2, 8'd11},
    '{2'b11, 8'd14, 8'd15, 2'b10, 2'b11, 3'd2, 3'd3, 4'd5, 2'd0, 8'd11},
    '{2'b00, 8'd0,  8'd0,  2'b00, 2'b01, 3'd4, 3'd0, 4'd7, 2'd2, 8'd13},
    '{2'b00, 8'd0,  8'd0,  2'b00, 2'b00, 3'd0, 3'd0, 4'd8, 2'd1, 8'd14},
    '{2'b11, 8'd20, 8'd21, 2'b00, 2'b00, 3'd0, 3'd0, 4'd6, 2'd0, 8'd14},
    '{2'b00, 8'd0,  8'd0,  2'b00, 2'b01, 3'd6, 3'd0, 4'd6, 2'd0, 8'd14},
    '{2'b00, 8'd0,  8'd0,  2'b00, 2'b00, 3'd0, 3'd0, 4'd6, 2'd0, 8'd14},
    '{2'b00, 8'd0,  8'd0,  2'b00, 2'b01, 3'd5, 3'd0, 4'd6, 2'd0, 8'd14},
    '{2'b00, 8'd0,  8'd0,  2'b00, 2'b00, 3'd0, 3'd0, 4'd8, 2'd2, 8'd21}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ins_valid = '0; ins_squashed = '0; ins_nonspec = '0; ins_branch = '0; ins_nop = '0;
    ins_seq = '0; ins_pc = '0; cmp_valid = '0; cmp_slot = '0;
    xs_valid = 1'b0; xs_seq = '0; xs_mispred = 1'b0; xs_taken = 1'b0;
    xs_next_pc = '0; xs_mis_pc = '0;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_reset();
    idle_inputs();
    rst = 1'b1;
    cyc(); cyc();
    rst = 1'b0;
  endtask

  task automatic put(input logic [1:0] v, input int s0, input int s1);
    ins_valid = v;
    ins_seq = {8'(s1), 8'(s0)};
    ins_pc = {16'(s1 * 4), 16'(s0 * 4)};
  endtask

  task automatic comp(input logic [1:0] v, input int a, input int b);
    cmp_valid = v;
    cmp_slot = {3'(b), 3'(a)};
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 state", ctl_state, 0);
    chk("R1 free", free_cnt, 8);
    chk("R1 ready", ins_ready, 1);
    chk("R1 done_seq", done_seq, 0);
    chk("R1 counters", cnt_committed + cnt_mispred + cnt_sq_retired, 0);
    cyc();
    chk("R10 idle holds with no insert", ctl_state, 0);

    // R2/R4/R5 table walk
    for (int i = 0; i < NV; i++) begin
      put(VT[i].v, VT[i].s0, VT[i].s1);
      ins_squashed = VT[i].sq;
      comp(VT[i].cv, VT[i].c0, VT[i].c1);
      cyc();
      chk($sformatf("R2 row%0d free", i), free_cnt, VT[i].free);
      chk($sformatf("R4 row%0d commit_num", i), commit_num, VT[i].cn);
      chk($sformatf("R5 row%0d done_seq", i), done_seq, VT[i].ds);
      if (i == 0) chk("R10 running after insert", ctl_state, 1);
    end
    chk("R5 committed count", cnt_committed, 7);
    chk("R5 nonnop count", cnt_nonnop, 7);

    // R3 full buffer, R5 branch and no-op tallies
    do_reset();
    put(2'b11, 1, 2); ins_branch = 2'b01; ins_nop = 2'b10; cyc();
    put(2'b11, 3, 4); cyc();
    put(2'b11, 5, 6); cyc();
    chk("R3 ready with two free", ins_ready, 1);
    put(2'b11, 7, 8); cyc();
    chk("R3 full free", free_cnt, 0);
    chk("R3 not ready when full", ins_ready, 0);
    put(2'b11, 9, 10); cyc();
    chk("R3 full group ignored", free_cnt, 0);
    comp(2'b11, 0, 1); cyc();
    comp(2'b11, 2, 3); cyc();
    comp(2'b11, 4, 5); cyc();
    comp(2'b11, 6, 7); cyc();
    cyc();
    chk("R3 drained free", free_cnt, 8);
    chk("R5 last done_seq", done_seq, 8);
    chk("R3 no extra commits", cnt_committed, 8);
    chk("R5 branch count", cnt_branch, 1);
    chk("R5 nonnop count full", cnt_nonnop, 7);

    // R7 non-speculative head
    do_reset();
    put(2'b11, 5, 6); ins_nonspec = 2'b01; cyc();
    comp(2'b01, 1, 0); cyc();
    chk("R7 request raised", ns_valid, 1);
    chk("R7 request seq", ns_seq, 5);
    chk("R7 no commit past head", commit_num, 0);
    cyc();
    chk("R7 request once", ns_valid, 0);
    chk("R7 still stalled", commit_num, 0);
    comp(2'b01, 0, 0); cyc();
    chk("R7 stalled in completion cycle", commit_num, 0);
    cyc();
    chk("R7 commit after completion", commit_num, 2);
    chk("R7 done_seq", done_seq, 6);

    // R8/R9/R6 squash walk
    do_reset();
    put(2'b11, 1, 2); cyc();
    put(2'b11, 3, 4); cyc();
    put(2'b11, 5, 6); cyc();
    xs_valid = 1'b1; xs_seq = 8'd2; xs_mispred = 1'b1; xs_taken = 1'b1;
    xs_next_pc = 16'h1234; xs_mis_pc = 16'h0ABC;
    put(2'b11, 7, 8);
    cyc();
    chk("R8 state squashing", ctl_state, 2);
    chk("R8 squash pulse", bk_squash, 1);
    chk("R8 rob squashing", bk_rob_squashing, 1);
    chk("R8 done_seq echo", done_seq, 2);
    chk("R8 mispred fwd", bk_mispred, 1);
    chk("R8 taken fwd", bk_taken, 1);
    chk("R8 next pc", bk_next_pc, 16'h1234);
    chk("R8 mis pc", bk_mis_pc, 16'h0ABC);
    chk("R8 mispred count", cnt_mispred, 1);
    chk("R3 group with squash dropped", free_cnt, 2);
    chk("R3 not ready while squashing", ins_ready, 0);
    cyc();
    chk("R9 step1 done_seq", done_seq, 4);
    chk("R9 step1 flag", bk_rob_squashing, 1);
    chk("R9 step1 squash pulse gone", bk_squash, 0);
    chk("R9 step1 state", ctl_state, 2);
    cyc();
    chk("R9 step2 done_seq", done_seq, 2);
    chk("R9 step2 flag", bk_rob_squashing, 1);
    cyc();
    chk("R9 walk finished", ctl_state, 1);
    chk("R9 flag clear", bk_rob_squashing, 0);
    comp(2'b11, 0, 1); cyc();
    chk("R4 head waits", commit_num, 0);
    chk("R9 squashed still held", free_cnt, 2);
    cyc();
    chk("R4 kept entries commit", commit_num, 2);
    chk("R5 kept done_seq", done_seq, 2);
    cyc();
    chk("R6 silent retire commit_num", commit_num, 0);
    chk("R6 silent retire free", free_cnt, 6);
    chk("R6 done_seq unchanged", done_seq, 2);
    cyc();
    chk("R6 drained", free_cnt, 8);
    chk("R6 squash retire count", cnt_sq_retired, 4);
    chk("R6 committed count", cnt_committed, 2);
    put(2'b01, 9, 0); cyc();
    xs_valid = 1'b1; xs_seq = 8'd20; xs_mispred = 1'b0; cyc();
    chk("R8 second squash pulse", bk_squash, 1);
    chk("R8 done_seq second", done_seq, 20);
    chk("R8 mispred count unchanged", cnt_mispred, 1);
    cyc();
    chk("R9 empty walk exits", ctl_state, 1);
    chk("R9 empty walk no flag", bk_rob_squashing, 0);
    chk("R9 nothing marked", free_cnt, 7);

    summary();
  end
endmodule